// File: doc/BRIEF.md
# Byte-wide SPI master with register interface

This block is a serial peripheral master that a processor controls through three byte-wide registers: control, status and data. A write to the data register loads a byte and starts a transfer. The byte goes out on the serial output with the most significant bit first, while eight bits are collected from the serial input. The serial clock comes from a divider of the system clock. Its idle level and its phase relative to the data are selectable.

When a byte has been exchanged, a completion flag is set, and an interrupt request follows that flag when interrupts are enabled. A data-register write that arrives while a byte is still moving does not disturb that transfer. It raises a collision flag instead. Flags are cleared in two steps. A status read records which flags are set at that moment, and the next read or write of the data register clears only those recorded flags.

The register port is a plain single-cycle interface with no handshake: `reg_sel` picks the register, `wr_en` writes `wdata`, and `rd_en` marks a read whose side effects take place at the next clock edge. `rdata` is combinational. A register access always completes in one cycle, so there is no back-pressure. The serial pins run free and have no flow control.

Top module: `spi_byte_master`

## Requirements
- R1: While `rst_n` is low, and after it is released, the control register and both flags read 0, any transfer in progress is dropped, the recorded flag capture is empty, `sck` is 0 and `mosi` is 0.
- R2: `reg_sel` 0 selects control, 1 selects status, 2 selects data, and 3 reads 0. Control bit 7 is interrupt enable, bit 6 is system enable, bit 5 is wire-OR mode (stored only), bit 4 is master select (stored only), bit 3 is clock polarity, bit 2 is clock phase, and bits 1:0 are the rate code. Control reads back as written. In the status register, bit 7 is completion, bit 6 is collision, bit 4 is mode fault (always 0), and all other bits are 0.
- R3: Rate codes 0, 1, 2 and 3 give an `sck` period of 2, 4, 16 and 32 system clocks. Each half period (1, 2, 8 or 16 clocks) is one tick. A byte lasts 16 ticks, so the completion flag becomes visible 16 half periods after the edge that accepted the data write.
- R4: A data-register write with system enable at 0 starts no transfer, sets no flag and clears no flag.
- R5: During a transfer, data bit 7-k is on `mosi` for ticks 2k and 2k+1. Outside a transfer `mosi` is 0.
- R6: Outside a transfer `sck` equals the polarity bit. In tick t of a transfer, `sck` equals polarity XOR phase XOR (t mod 2). With phase 0, the first edge therefore falls mid-bit. With phase 1, it falls at the start of the bit.
- R7: `miso` is sampled at the end of each even tick and shifted in from the least significant end. The data register reads the last fully received byte, which is updated when the transfer ends.
- R8: The completion flag is set at the end of tick 15. `irq` is high exactly while the completion flag and interrupt enable are both 1.
- R9: A data write with system enable at 1 during a transfer sets the collision flag and leaves the byte being shifted and the transfer timing unchanged.
- R10: Writes to the status register change no flag.
- R11: A status read captures the flags set at that moment. The next data read, or data write with system enable at 1, clears only the captured flags and empties the capture. A flag set later survives that access. A flag being set wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; side effects at the next edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data of the selected register |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
On every cycle, the bound checker confirms several local rules. Each flag rises only from its own cause. A collision write never cuts a transfer short. A disabled data write never starts one. Status writes leave the flags alone. `mosi` holds between `sck` edges, and `sck` stays still while idle. The bit order, the exact waveform for each polarity and phase, the duration at each rate, the received byte and the two-step clear all depend on what came earlier in a sequence. Only the bench's cycle-accurate reference model shows these, by comparing the pins each clock and checking register reads after chosen access orders.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CTL_IE  = 7;
  localparam int CTL_EN  = 6;
  localparam int CTL_POL = 3;
  localparam int CTL_PHA = 2;

  localparam int ST_DONE  = 7;
  localparam int ST_COLL  = 6;
  localparam int ST_FAULT = 4;
endpackage

// File: rtl/spi_bm_rate.sv
module spi_bm_rate #(
  parameter int HALF_LEN0 = 1,
  parameter int HALF_LEN1 = 2,
  parameter int HALF_LEN2 = 8,
  parameter int HALF_LEN3 = 16,
  parameter int CNT_W     = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] rate,
  output logic       tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb begin
    unique case (rate)
      2'd0:    lim = CNT_W'(HALF_LEN0 - 1);
      2'd1:    lim = CNT_W'(HALF_LEN1 - 1);
      2'd2:    lim = CNT_W'(HALF_LEN2 - 1);
      default: lim = CNT_W'(HALF_LEN3 - 1);
    endcase
  end

  assign tick = run && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (restart || !run || tick) cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_bm_shift.sv
module spi_bm_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] load_val,
  input  logic              tick,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sck,
  output logic              mosi
);
  localparam int HALVES = 2 * DATA_W;
  localparam int H_W    = $clog2(HALVES);

  logic [H_W-1:0]    half;
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;
  logic              last_half;

  assign last_half = (half == H_W'(HALVES - 1));
  assign done      = busy && tick && last_half;
  assign sck       = busy ? (cpol ^ cpha ^ half[0]) : cpol;
  assign mosi      = busy & tx_sr[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      half    <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_byte <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      half  <= '0;
      tx_sr <= load_val;
    end else if (busy && tick) begin
      half <= half + 1'b1;
      if (!half[0]) begin
        rx_sr <= {rx_sr[DATA_W-2:0], miso};
      end else if (!last_half) begin
        tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      end
      if (last_half) begin
        busy    <= 1'b0;
        rx_byte <= rx_sr;
      end
    end
  end
endmodule

// File: rtl/spi_bm_regs.sv
module spi_bm_regs
  import spi_bm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              start,
  output logic              sys_en,
  output logic              cpol,
  output logic              cpha,
  output logic [1:0]        rate,
  output logic              flag_done,
  output logic              flag_coll,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] ctrl_q;
  logic              cap_done;
  logic              cap_coll;
  logic              data_hit;
  logic              coll;
  logic              clr;
  logic [DATA_W-1:0] stat_word;

  assign sel      = reg_sel_e'(reg_sel);
  assign sys_en   = ctrl_q[CTL_EN];
  assign cpol     = ctrl_q[CTL_POL];
  assign cpha     = ctrl_q[CTL_PHA];
  assign rate     = ctrl_q[1:0];
  assign data_hit = (sel == SEL_DATA);
  assign start    = wr_en && data_hit && sys_en && !busy;
  assign coll     = wr_en && data_hit && sys_en && busy;
  assign clr      = data_hit && (rd_en || (wr_en && sys_en));
  assign irq      = flag_done & ctrl_q[CTL_IE];

  always_comb begin
    stat_word           = '0;
    stat_word[ST_DONE]  = flag_done;
    stat_word[ST_COLL]  = flag_coll;
    stat_word[ST_FAULT] = 1'b0;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: rdata = ctrl_q;
      SEL_STAT: rdata = stat_word;
      SEL_DATA: rdata = rx_byte;
      default:  rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      flag_done <= 1'b0;
      flag_coll <= 1'b0;
      cap_done  <= 1'b0;
      cap_coll  <= 1'b0;
    end else begin
      if (wr_en && sel == SEL_CTRL) ctrl_q <= wdata;
      if (rd_en && sel == SEL_STAT) begin
        cap_done <= flag_done;
        cap_coll <= flag_coll;
      end else if (clr) begin
        cap_done <= 1'b0;
        cap_coll <= 1'b0;
      end
      flag_done <= done | (flag_done & ~(clr & cap_done));
      flag_coll <= coll | (flag_coll & ~(clr & cap_coll));
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int DATA_W    = 8,
  parameter int HALF_LEN0 = 1,
  parameter int HALF_LEN1 = 2,
  parameter int HALF_LEN2 = 8,
  parameter int HALF_LEN3 = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  localparam int CNT_W = $clog2(HALF_LEN3 + 1);

  logic              start;
  logic              sys_en;
  logic              cpol;
  logic              cpha;
  logic [1:0]        rate;
  logic              flag_done;
  logic              flag_coll;
  logic              busy;
  logic              xfer_done;
  logic              tick;
  logic [DATA_W-1:0] rx_byte;

  spi_bm_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .busy(busy), .done(xfer_done), .rx_byte(rx_byte),
    .start(start), .sys_en(sys_en), .cpol(cpol), .cpha(cpha), .rate(rate),
    .flag_done(flag_done), .flag_coll(flag_coll), .rdata(rdata), .irq(irq)
  );

  spi_bm_rate #(
    .HALF_LEN0(HALF_LEN0), .HALF_LEN1(HALF_LEN1),
    .HALF_LEN2(HALF_LEN2), .HALF_LEN3(HALF_LEN3), .CNT_W(CNT_W)
  ) u_rate (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(start), .rate(rate), .tick(tick)
  );

  spi_bm_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .load_val(wdata), .tick(tick),
    .cpol(cpol), .cpha(cpha), .miso(miso), .busy(busy), .done(xfer_done),
    .rx_byte(rx_byte), .sck(sck), .mosi(mosi)
  );
endmodule

// File: rtl/spi_bm_chk.sv
module spi_bm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_sel,
  input logic       wr_en,
  input logic       sys_en,
  input logic       cpol,
  input logic       busy,
  input logic       xfer_done,
  input logic       flag_done,
  input logic       flag_coll,
  input logic       sck,
  input logic       mosi
);
  // R8
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_done) |-> $past(busy));

  // R9
  coll_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_coll) |-> $past(wr_en && reg_sel == 2'd2 && busy));

  // R9
  coll_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd2 && busy && !xfer_done) |=> busy);

  // R4
  off_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd2 && !sys_en && !busy) |=> !busy);

  // R10
  stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd1 && !xfer_done) |=> ($stable(flag_done) && $stable(flag_coll)));

  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(sck)) |-> $stable(mosi));

  // R6
  idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(cpol)) |-> $stable(sck));
endmodule

bind spi_byte_master spi_bm_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .sys_en(sys_en),
  .cpol(cpol), .busy(busy), .xfer_done(xfer_done), .flag_done(flag_done),
  .flag_coll(flag_coll), .sck(sck), .mosi(mosi)
);

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd3;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, sck, mosi;
  logic       miso = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_byte_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
  );

  // reference model state
  logic [7:0] m_ctrl, m_tx, m_acc, m_rx;
  bit m_busy, m_spif, m_wcol, m_cap_s, m_cap_w;
  int m_el;

  function automatic int half_clocks(input logic [1:0] code);
    case (code)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int dd, hh;
    bit done_e, start_e, coll_e, clr_e;
    if (!rst_n) begin
      m_ctrl = 0; m_tx = 0; m_acc = 0; m_rx = 0; m_el = 0;
      m_busy = 0; m_spif = 0; m_wcol = 0; m_cap_s = 0; m_cap_w = 0;
    end else begin
      dd = half_clocks(m_ctrl[1:0]);
      done_e = 0;
      if (m_busy) begin
        hh = m_el / dd;
        if (m_el % dd == dd - 1) begin
          if (hh % 2 == 0) m_acc = {m_acc[6:0], miso};
          if (hh == 15) begin done_e = 1; m_rx = m_acc; end
        end
        m_el++;
      end
      start_e = wr_en && reg_sel == 2 && m_ctrl[6] && !m_busy;
      coll_e  = wr_en && reg_sel == 2 && m_ctrl[6] && m_busy;
      clr_e   = reg_sel == 2 && (rd_en || (wr_en && m_ctrl[6]));
      if (rd_en && reg_sel == 1) begin
        m_cap_s = m_spif; m_cap_w = m_wcol;
      end else if (clr_e) begin
        if (m_cap_s) m_spif = 0;
        if (m_cap_w) m_wcol = 0;
        m_cap_s = 0; m_cap_w = 0;
      end
      if (done_e) begin m_spif = 1; m_busy = 0; end
      if (coll_e) m_wcol = 1;
      if (start_e) begin m_busy = 1; m_el = 0; m_tx = wdata; end
      if (wr_en && reg_sel == 0) m_ctrl = wdata;
    end
  end

  function automatic logic exp_sck();
    int hh;
    if (!m_busy) return m_ctrl[3];
    hh = m_el / half_clocks(m_ctrl[1:0]);
    return m_ctrl[3] ^ m_ctrl[2] ^ hh[0];
  endfunction

  function automatic logic exp_mosi();
    int hh;
    if (!m_busy) return 1'b0;
    hh = m_el / half_clocks(m_ctrl[1:0]);
    return m_tx[7 - hh / 2];
  endfunction

  function automatic logic [7:0] exp_rdata(input logic [1:0] s);
    case (s)
      2'd0: return m_ctrl;
      2'd1: return {m_spif, m_wcol, 6'b0};
      2'd2: return m_rx;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R6 sck", sck, exp_sck());
      check("R5 mosi", mosi, exp_mosi());
      check("R8 irq", irq, m_spif & m_ctrl[7]);
    end
  end

  // serial input pattern
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso <= lfsr[0];
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1; reg_sel = s; wdata = v;
    @(negedge clk);
    wr_en = 0; reg_sel = 2'd3;
  endtask

  task automatic rd(input logic [1:0] s, input string req);
    @(negedge clk);
    rd_en = 1; reg_sel = s;
    #1;
    check(req, rdata, exp_rdata(s));
    @(negedge clk);
    rd_en = 0; reg_sel = 2'd3;
  endtask

  task automatic idle_wait();
    for (int i = 0; i < 2000 && m_busy; i++) @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=hung expected=done");
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sck reset", sck, 0);
    check("R1 mosi reset", mosi, 0);
    rst_n = 1;
    rd(2'd0, "R1 ctrl");
    rd(2'd1, "R1 status");
    rd(2'd2, "R1 data");

    // R2 readback and unused select
    wr(2'd0, 8'h3C);
    rd(2'd0, "R2 ctrl readback");
    rd(2'd3, "R2 sel3");
    wr(2'd0, 8'h08);
    check("R6 idle cpol", sck, 1);

    // R4 disabled write
    wr(2'd2, 8'h3C);
    repeat (40) @(negedge clk);
    check("R4 no start", sck, 1);
    rd(2'd1, "R4 status");

    // R3/R7/R8 all rates and modes
    for (int i = 0; i < 4; i++) begin
      int cnt;
      wr(2'd0, 8'hC0 | 8'(i) | (8'(i) << 2));
      wr(2'd2, 8'hA5 ^ 8'(i * 37));
      cnt = 0;
      while (!irq && cnt < 1000) begin @(negedge clk); cnt++; end
      check("R3 duration", cnt, 16 * half_clocks(2'(i)));
      rd(2'd1, "R8 status done");
      rd(2'd2, "R7 rx byte");
      rd(2'd1, "R11 cleared");
      check("R8 irq low", irq, 0);
    end

    // R9 collision
    wr(2'd0, 8'hC5);
    wr(2'd2, 8'h5A);
    repeat (5) @(negedge clk);
    wr(2'd2, 8'hFF);
    idle_wait();
    @(negedge clk);
    rd(2'd1, "R9 collision flag");
    rd(2'd2, "R9 rx");
    rd(2'd1, "R9 cleared");

    // R10 status write ignored
    wr(2'd2, 8'h81);
    idle_wait();
    @(negedge clk);
    wr(2'd1, 8'h00);
    rd(2'd1, "R10 status kept");

    // R11 write-side clear: status captured, data write clears and starts
    wr(2'd2, 8'h3E);
    rd(2'd1, "R11 cleared by write");
    // capture during transfer holds nothing; later flag survives
    rd(2'd1, "R11 capture empty");
    idle_wait();
    @(negedge clk);
    rd(2'd2, "R11 data read");
    rd(2'd1, "R11 flag survives");
    rd(2'd2, "R11 clear");
    rd(2'd1, "R11 final");

    // R1 reset mid transfer
    wr(2'd0, 8'hCB);
    wr(2'd2, 8'h77);
    repeat (10) @(negedge clk);
    rst_n = 0;
    #1;
    check("R1 sck abort", sck, 0);
    check("R1 mosi abort", mosi, 0);
    @(negedge clk);
    rst_n = 1;
    rd(2'd0, "R1 ctrl after");
    rd(2'd1, "R1 status after");
    repeat (20) @(negedge clk);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule